// File: doc/BRIEF.md
# Serial Two-Wire Register and Indirect RAM Slave

This block is a two-wire serial bus slave (I2C protocol, 7-bit addressing) that gives a host access to an 8-bit addressed register space and to two indirect memory ports. It samples the bus lines with the system clock, finds START and STOP conditions, and shifts bytes in and out. The first byte of a write selects a register index, and each following data byte goes to the current index, which then steps by one. The block only pulls lines low. SDA is driven through an open-drain enable, and SCL is never held, because clock stretching is not supported.

Two index values are reserved as gateways. Index FEh, followed by a memory address byte, opens a byte-wide sequential port to a cursor bitmap memory. Index FFh, followed by a memory address byte, opens a port to a colour lookup table. That port moves each entry as three bytes, red then green then blue, and the block assembles them into one 24-bit word. A read is set up by a write of the index (and the memory address for the two ports), then a repeated START with the read address. The master acknowledges every byte except the last.

Two register indices are status bytes and cannot be written: one carries a status value, and one carries the chip identity at index 1Ch. The storage behind all ports sits outside this block. The block gives write strobes with address and data, and takes read data back through input ports that follow the address it presents.

Top module: `i2c_reg_slave`

## Requirements
- R1: The block answers only to the 7-bit address 1000100b. It acknowledges 88h (write) and 89h (read). Any other address byte gets no acknowledge and causes no write for the rest of that transfer.
- R2: In a write, the first byte after the address is taken as the register index. Each following data byte is acknowledged and produces one `reg_wr_stb` pulse with `reg_addr` equal to the current index. The index then increments by one (modulo 256).
- R3: Data bytes sent to the read-only indices (00h and 1Ch by default) are acknowledged but produce no strobe. The index still increments past them.
- R4: After a repeated START with address 89h, the block returns `reg_rd_data` for consecutive indices, starting at the last index written, MSB first. After the master's NACK it releases SDA and transmits nothing more.
- R5: Index FEh followed by an address byte writes each later data byte to the cursor port (`cur_wr_stb`) at consecutive addresses. The address wraps at 2^CUR_AW.
- R6: Index FFh followed by an address byte collects data bytes in groups of three (red, green, blue). Each complete group produces one `lut_wr_stb` with `lut_wr_data` = {red[23:16], green[15:8], blue[7:0]}, and the table address then increments, wrapping at 2^LUT_AW. An incomplete group produces no write.
- R7: Reads in cursor mode return `cur_rd_data` at consecutive addresses. Reads in lookup-table mode return the red, green and blue bytes of one entry in that order, then move to the next entry.
- R8: A STOP or a START that arrives before a byte is complete discards the partial byte without any write. The next transfer is served normally, and a new write address always expects a fresh index byte.
- R9: Out of reset, and outside its own acknowledge and read-data slots, the block does not pull SDA low. It never pulls SCL low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the pad |
| sda_in | input | 1 | Serial data line as seen on the pad |
| scl_drive_low | output | 1 | Open-drain pull-down enable for SCL (always 0) |
| sda_drive_low | output | 1 | Open-drain pull-down enable for SDA |
| reg_wr_stb | output | 1 | One-cycle register write strobe |
| reg_addr | output | 8 | Register index for write or read |
| reg_wr_data | output | 8 | Register write data |
| reg_rd_data | input | 8 | Register read data at `reg_addr` |
| cur_wr_stb | output | 1 | One-cycle cursor memory write strobe |
| cur_addr | output | CUR_AW | Cursor memory address |
| cur_wr_data | output | 8 | Cursor memory write data |
| cur_rd_data | input | 8 | Cursor memory read data at `cur_addr` |
| lut_wr_stb | output | 1 | One-cycle lookup table write strobe |
| lut_addr | output | LUT_AW | Lookup table entry address |
| lut_wr_data | output | 24 | Lookup table entry {red, green, blue} |
| lut_rd_data | input | 24 | Lookup table entry at `lut_addr` |

## Verification
The bench builds the block with CUR_AW = 4 and LUT_AW = 3. With these widths, address wrap in both memory ports is reached within a dozen bytes, while the register space keeps its full 8-bit width. Because of that, one burst sweeps every ordinary index from 00h to FDh, including both read-only ones, and one read burst returns all of them. Triplets that straddle the lookup table's last entry, an incomplete triplet, and transfers cut by STOP or START mid-byte are all driven, with expected contents computed from the index arithmetic.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_RX_ADDR,
        LK_ADDR_ACK,
        LK_RX_DATA,
        LK_DATA_ACK,
        LK_TX_DATA,
        LK_TX_ACK,
        LK_WAIT_END
    } link_state_e;

    typedef enum logic [1:0] {
        AM_REG,
        AM_CURSOR,
        AM_PALETTE
    } acc_mode_e;

    typedef enum logic [1:0] {
        PH_INDEX,
        PH_RAMADDR,
        PH_DATA
    } acc_phase_e;

    localparam logic [7:0] IDX_CURSOR_PORT  = 8'hFE;
    localparam logic [7:0] IDX_PALETTE_PORT = 8'hFF;
    localparam int         BYTE_W           = 8;
    localparam int         RGB_W            = 3 * BYTE_W;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int LINES = 2;
    localparam int SCL_I = 1;
    localparam int SDA_I = 0;

    typedef struct packed {
        logic [LINES-1:0][STAGES-1:0] pipe;
        logic [LINES-1:0]             prev;
    } sync_t;

    sync_t d, q;
    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;

    assign raw = {scl_raw, sda_raw};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            assign lvl[g] = q.pipe[g][STAGES-1];
        end
    endgenerate

    always_comb begin
        d = q;
        for (int i = 0; i < LINES; i++) begin
            d.pipe[i] = {q.pipe[i][STAGES-2:0], raw[i]};
            d.prev[i] = lvl[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_lvl   = lvl[SCL_I];
    assign sda_lvl   = lvl[SDA_I];
    assign scl_rise  = lvl[SCL_I] & ~q.prev[SCL_I];
    assign scl_fall  = ~lvl[SCL_I] & q.prev[SCL_I];
    assign start_det = lvl[SCL_I] & q.prev[SCL_I] & q.prev[SDA_I] & ~lvl[SDA_I];
    assign stop_det  = lvl[SCL_I] & q.prev[SCL_I] & ~q.prev[SDA_I] & lvl[SDA_I];

endmodule

// File: rtl/i2c_byte_link.sv
module i2c_byte_link
    import i2c_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              ev_sof_wr,
    output logic              ev_wr,
    output logic [BYTE_W-1:0] ev_byte,
    output logic              ev_rd
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        link_state_e       state;
        logic [CNT_W-1:0]  bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic              is_read;
        logic              ack_flag;
        logic              sda_oe;
    } link_t;

    link_t d, q;
    logic [BYTE_W-1:0] rx_next;

    always_comb begin
        d         = q;
        ev_sof_wr = 1'b0;
        ev_wr     = 1'b0;
        ev_rd     = 1'b0;
        rx_next   = {q.shreg[BYTE_W-2:0], sda_lvl};
        ev_byte   = rx_next;

        if (start_det) begin
            d.state    = LK_RX_ADDR;
            d.bitcnt   = '0;
            d.sda_oe   = 1'b0;
            d.ack_flag = 1'b0;
        end else if (stop_det) begin
            d.state  = LK_IDLE;
            d.sda_oe = 1'b0;
        end else begin
            unique case (q.state)
                LK_RX_ADDR, LK_RX_DATA: begin
                    if (scl_rise) begin
                        d.shreg    = rx_next;
                        d.bitcnt   = q.bitcnt + 1'b1;
                        d.ack_flag = 1'b0;
                        if (q.bitcnt == LAST_BIT) begin
                            if (q.state == LK_RX_ADDR) begin
                                if (rx_next[BYTE_W-1:1] == DEV_ADDR) begin
                                    d.state   = LK_ADDR_ACK;
                                    d.is_read = rx_next[0];
                                    ev_sof_wr = ~rx_next[0];
                                end else begin
                                    d.state = LK_WAIT_END;
                                end
                            end else begin
                                ev_wr   = 1'b1;
                                d.state = LK_DATA_ACK;
                            end
                        end
                    end
                end
                LK_ADDR_ACK, LK_DATA_ACK: begin
                    if (scl_fall) begin
                        if (!q.ack_flag) begin
                            d.sda_oe   = 1'b1;
                            d.ack_flag = 1'b1;
                        end else begin
                            d.ack_flag = 1'b0;
                            d.bitcnt   = '0;
                            if (q.state == LK_ADDR_ACK && q.is_read) begin
                                ev_rd    = 1'b1;
                                d.shreg  = tx_byte;
                                d.sda_oe = ~tx_byte[BYTE_W-1];
                                d.state  = LK_TX_DATA;
                            end else begin
                                d.sda_oe = 1'b0;
                                d.state  = LK_RX_DATA;
                            end
                        end
                    end
                end
                LK_TX_DATA: begin
                    if (scl_fall) begin
                        if (q.bitcnt == LAST_BIT) begin
                            d.sda_oe   = 1'b0;
                            d.ack_flag = 1'b0;
                            d.state    = LK_TX_ACK;
                        end else begin
                            d.bitcnt = q.bitcnt + 1'b1;
                            d.shreg  = q.shreg << 1;
                            d.sda_oe = ~q.shreg[BYTE_W-2];
                        end
                    end
                end
                LK_TX_ACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) d.state    = LK_WAIT_END;
                        else         d.ack_flag = 1'b1;
                    end else if (scl_fall && q.ack_flag) begin
                        ev_rd      = 1'b1;
                        d.ack_flag = 1'b0;
                        d.bitcnt   = '0;
                        d.shreg    = tx_byte;
                        d.sda_oe   = ~tx_byte[BYTE_W-1];
                        d.state    = LK_TX_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= LK_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.sda_oe;

    // R8: a STOP always leaves the byte engine idle
    a_r8_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (q.state == LK_IDLE));

    // R1: the address acknowledge slot is entered only from a completed address byte
    a_r1_ack_from_address: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == LK_ADDR_ACK && $past(q.state) != LK_ADDR_ACK) |-> $past(q.state) == LK_RX_ADDR);

endmodule

// File: rtl/i2c_access_ctrl.sv
module i2c_access_ctrl
    import i2c_reg_pkg::*;
#(
    parameter int         CUR_AW   = 8,
    parameter int         LUT_AW   = 8,
    parameter logic [7:0] RO_IDX_A = 8'h00,
    parameter logic [7:0] RO_IDX_B = 8'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_sof_wr,
    input  logic              ev_wr,
    input  logic [BYTE_W-1:0] ev_byte,
    input  logic              ev_rd,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              reg_wr_stb,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wr_data,
    input  logic [BYTE_W-1:0] reg_rd_data,
    output logic              cur_wr_stb,
    output logic [CUR_AW-1:0] cur_addr,
    output logic [BYTE_W-1:0] cur_wr_data,
    input  logic [BYTE_W-1:0] cur_rd_data,
    output logic              lut_wr_stb,
    output logic [LUT_AW-1:0] lut_addr,
    output logic [RGB_W-1:0]  lut_wr_data,
    input  logic [RGB_W-1:0]  lut_rd_data
);

    localparam logic [1:0] LAST_COMP = 2'd2;

    typedef struct packed {
        acc_mode_e         mode;
        acc_phase_e        phase;
        logic [BYTE_W-1:0] idx;
        logic [CUR_AW-1:0] cptr;
        logic [LUT_AW-1:0] lptr;
        logic [1:0]        comp;
        logic [BYTE_W-1:0] red;
        logic [BYTE_W-1:0] green;
        logic              reg_stb;
        logic [BYTE_W-1:0] reg_wa;
        logic [BYTE_W-1:0] wdata;
        logic              cur_stb;
        logic [CUR_AW-1:0] cur_wa;
        logic              lut_stb;
        logic [LUT_AW-1:0] lut_wa;
        logic [RGB_W-1:0]  lut_wd;
    } ctrl_t;

    ctrl_t d, q;
    logic  idx_is_ro;

    assign idx_is_ro = (q.idx == RO_IDX_A) || (q.idx == RO_IDX_B);

    always_comb begin
        d         = q;
        d.reg_stb = 1'b0;
        d.cur_stb = 1'b0;
        d.lut_stb = 1'b0;

        if (ev_sof_wr) begin
            d.phase = PH_INDEX;
        end else if (ev_wr) begin
            unique case (q.phase)
                PH_INDEX: begin
                    if (ev_byte == IDX_CURSOR_PORT) begin
                        d.mode  = AM_CURSOR;
                        d.phase = PH_RAMADDR;
                    end else if (ev_byte == IDX_PALETTE_PORT) begin
                        d.mode  = AM_PALETTE;
                        d.phase = PH_RAMADDR;
                    end else begin
                        d.mode  = AM_REG;
                        d.idx   = ev_byte;
                        d.phase = PH_DATA;
                    end
                end
                PH_RAMADDR: begin
                    d.cptr  = ev_byte[CUR_AW-1:0];
                    d.lptr  = ev_byte[LUT_AW-1:0];
                    d.comp  = '0;
                    d.phase = PH_DATA;
                end
                default: begin
                    unique case (q.mode)
                        AM_CURSOR: begin
                            d.cur_stb = 1'b1;
                            d.cur_wa  = q.cptr;
                            d.wdata   = ev_byte;
                            d.cptr    = q.cptr + 1'b1;
                        end
                        AM_PALETTE: begin
                            if (q.comp == 2'd0) begin
                                d.red  = ev_byte;
                                d.comp = 2'd1;
                            end else if (q.comp == 2'd1) begin
                                d.green = ev_byte;
                                d.comp  = LAST_COMP;
                            end else begin
                                d.lut_stb = 1'b1;
                                d.lut_wa  = q.lptr;
                                d.lut_wd  = {q.red, q.green, ev_byte};
                                d.lptr    = q.lptr + 1'b1;
                                d.comp    = 2'd0;
                            end
                        end
                        default: begin
                            if (!idx_is_ro) begin
                                d.reg_stb = 1'b1;
                                d.reg_wa  = q.idx;
                                d.wdata   = ev_byte;
                            end
                            d.idx = q.idx + 1'b1;
                        end
                    endcase
                end
            endcase
        end else if (ev_rd) begin
            unique case (q.mode)
                AM_CURSOR: d.cptr = q.cptr + 1'b1;
                AM_PALETTE: begin
                    if (q.comp == LAST_COMP) begin
                        d.comp = 2'd0;
                        d.lptr = q.lptr + 1'b1;
                    end else begin
                        d.comp = q.comp + 1'b1;
                    end
                end
                default: d.idx = q.idx + 1'b1;
            endcase
        end
    end

    always_comb begin
        unique case (q.mode)
            AM_CURSOR:  tx_byte = cur_rd_data;
            AM_PALETTE: begin
                if (q.comp == 2'd0)      tx_byte = lut_rd_data[RGB_W-1 -: BYTE_W];
                else if (q.comp == 2'd1) tx_byte = lut_rd_data[2*BYTE_W-1 -: BYTE_W];
                else                     tx_byte = lut_rd_data[BYTE_W-1:0];
            end
            default:    tx_byte = reg_rd_data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.mode  <= AM_REG;
            q.phase <= PH_INDEX;
        end else begin
            q <= d;
        end
    end

    assign reg_wr_stb  = q.reg_stb;
    assign reg_addr    = q.reg_stb ? q.reg_wa : q.idx;
    assign reg_wr_data = q.wdata;
    assign cur_wr_stb  = q.cur_stb;
    assign cur_addr    = q.cur_stb ? q.cur_wa : q.cptr;
    assign cur_wr_data = q.wdata;
    assign lut_wr_stb  = q.lut_stb;
    assign lut_addr    = q.lut_stb ? q.lut_wa : q.lptr;
    assign lut_wr_data = q.lut_wd;

    // R3: no strobe ever reaches a read-only index
    a_r3_ro_protected: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_stb |-> (reg_addr != RO_IDX_A && reg_addr != RO_IDX_B));

    // R2: one byte produces at most one strobe on one port
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_stb, cur_wr_stb, lut_wr_stb}));

    // R6: table writes are at least a full triplet apart
    a_r6_triplet_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        lut_wr_stb |=> !lut_wr_stb);

    // R5: consecutive cursor writes land on consecutive addresses
    a_r5_cursor_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_wr_stb && !ev_sof_wr && !ev_wr) |=> (cur_addr == $past(cur_addr) + 1'b1));

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h44,
    parameter int         CUR_AW      = 8,
    parameter int         LUT_AW      = 8,
    parameter logic [7:0] RO_IDX_A    = 8'h00,
    parameter logic [7:0] RO_IDX_B    = 8'h1C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic              reg_wr_stb,
    output logic [7:0]        reg_addr,
    output logic [7:0]        reg_wr_data,
    input  logic [7:0]        reg_rd_data,
    output logic              cur_wr_stb,
    output logic [CUR_AW-1:0] cur_addr,
    output logic [7:0]        cur_wr_data,
    input  logic [7:0]        cur_rd_data,
    output logic              lut_wr_stb,
    output logic [LUT_AW-1:0] lut_addr,
    output logic [23:0]       lut_wr_data,
    input  logic [23:0]       lut_rd_data
);

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              ev_sof_wr, ev_wr, ev_rd;
    logic [BYTE_W-1:0] ev_byte, tx_byte;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_byte_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .tx_byte   (tx_byte),
        .sda_oe    (sda_drive_low),
        .ev_sof_wr (ev_sof_wr),
        .ev_wr     (ev_wr),
        .ev_byte   (ev_byte),
        .ev_rd     (ev_rd)
    );

    i2c_access_ctrl #(
        .CUR_AW   (CUR_AW),
        .LUT_AW   (LUT_AW),
        .RO_IDX_A (RO_IDX_A),
        .RO_IDX_B (RO_IDX_B)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_sof_wr   (ev_sof_wr),
        .ev_wr       (ev_wr),
        .ev_byte     (ev_byte),
        .ev_rd       (ev_rd),
        .tx_byte     (tx_byte),
        .reg_wr_stb  (reg_wr_stb),
        .reg_addr    (reg_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .cur_wr_stb  (cur_wr_stb),
        .cur_addr    (cur_addr),
        .cur_wr_data (cur_wr_data),
        .cur_rd_data (cur_rd_data),
        .lut_wr_stb  (lut_wr_stb),
        .lut_addr    (lut_addr),
        .lut_wr_data (lut_wr_data),
        .lut_rd_data (lut_rd_data)
    );

    assign scl_drive_low = 1'b0;

    // R9: SDA only changes while SCL is low (outside START/STOP handling)
    a_r9_sda_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(stop_det))
            |-> $stable(sda_drive_low));

endmodule

// File: tb/sim_i2c_reg_slave.sv
module sim_i2c_reg_slave;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;
    localparam int CUR_AW     = 4;
    localparam int LUT_AW     = 3;
    localparam int CUR_N      = 1 << CUR_AW;
    localparam int LUT_N      = 1 << LUT_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;

    logic              scl_drive_low, sda_drive_low;
    logic              reg_wr_stb, cur_wr_stb, lut_wr_stb;
    logic [7:0]        reg_addr, reg_wr_data, reg_rd_data;
    logic [CUR_AW-1:0] cur_addr;
    logic [7:0]        cur_wr_data, cur_rd_data;
    logic [LUT_AW-1:0] lut_addr;
    logic [23:0]       lut_wr_data, lut_rd_data;
    logic              scl_w, sda_w;

    logic [7:0]  reg_mem [256];
    logic [7:0]  cur_mem [CUR_N];
    logic [23:0] lut_mem [LUT_N];
    logic [7:0]  exp_cur [CUR_N];
    logic [23:0] exp_lut [LUT_N];
    int reg_cnt = 0;
    int cur_cnt = 0;
    int lut_cnt = 0;
    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_w = m_scl & ~scl_drive_low;
    assign sda_w = m_sda & ~sda_drive_low;

    i2c_reg_slave #(.CUR_AW(CUR_AW), .LUT_AW(LUT_AW)) u0 (
        .clk (clk), .rst_n (rst_n), .scl_in (scl_w), .sda_in (sda_w),
        .scl_drive_low (scl_drive_low), .sda_drive_low (sda_drive_low),
        .reg_wr_stb (reg_wr_stb), .reg_addr (reg_addr), .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data), .cur_wr_stb (cur_wr_stb), .cur_addr (cur_addr),
        .cur_wr_data (cur_wr_data), .cur_rd_data (cur_rd_data), .lut_wr_stb (lut_wr_stb),
        .lut_addr (lut_addr), .lut_wr_data (lut_wr_data), .lut_rd_data (lut_rd_data)
    );

    assign reg_rd_data = reg_mem[reg_addr];
    assign cur_rd_data = cur_mem[cur_addr];
    assign lut_rd_data = lut_mem[lut_addr];

    always @(posedge clk) begin
        if (reg_wr_stb) begin reg_mem[reg_addr] <= reg_wr_data; reg_cnt <= reg_cnt + 1; end
        if (cur_wr_stb) begin cur_mem[cur_addr] <= cur_wr_data; cur_cnt <= cur_cnt + 1; end
        if (lut_wr_stb) begin lut_mem[lut_addr] <= lut_wr_data; lut_cnt <= lut_cnt + 1; end
    end

    function automatic logic [7:0] reg_init(input int i);
        return ~8'(i);
    endfunction

    function automatic logic [7:0] reg_pat(input int i);
        return 8'(i * 7 + 19);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic bit_out(input logic b);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_w;    tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic byte_out(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic byte_in(output logic [7:0] v, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(~ack);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] rd;
        int         base;

        for (int i = 0; i < 256; i++) reg_mem[i] = reg_init(i);
        for (int i = 0; i < CUR_N; i++) begin
            cur_mem[i] = 8'(i * 3);
            exp_cur[i] = 8'(i * 3);
        end
        for (int i = 0; i < LUT_N; i++) begin
            lut_mem[i] = 24'(i * 24'h010101);
            exp_lut[i] = 24'(i * 24'h010101);
        end

        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R9: reset state
        chk("R9 sda released after reset", 32'(sda_drive_low), 0);
        chk("R9 scl released after reset", 32'(scl_drive_low), 0);
        chk("R9 no strobe after reset", 32'({reg_wr_stb, cur_wr_stb, lut_wr_stb}), 0);

        // R1: foreign address is not acknowledged and writes nothing
        bus_start();
        byte_out(8'h8A, ack);
        chk("R1 foreign address nack", 32'(ack), 0);
        byte_out(8'h20, ack);
        chk("R1 data after foreign address nack", 32'(ack), 0);
        bus_stop();
        chk("R1 no write after foreign address", reg_cnt, 0);

        // R2/R3: full write sweep of indices 00h..FDh
        bus_start();
        byte_out(8'h88, ack);
        chk("R1 write address ack", 32'(ack), 1);
        byte_out(8'h00, ack);
        chk("R2 index byte ack", 32'(ack), 1);
        for (int i = 0; i < 254; i++) begin
            byte_out(reg_pat(i), ack);
            chk("R2 data byte ack", 32'(ack), 1);
        end
        bus_stop();
        for (int i = 0; i < 254; i++) begin
            if (i == 8'h00 || i == 8'h1C)
                chk("R3 read-only index unchanged", 32'(reg_mem[i]), 32'(reg_init(i)));
            else
                chk("R2 register written at auto-incremented index", 32'(reg_mem[i]), 32'(reg_pat(i)));
        end
        chk("R3 strobe count skips read-only", reg_cnt, 252);

        // R4: read sweep after repeated start
        bus_start();
        byte_out(8'h88, ack);
        byte_out(8'h00, ack);
        bus_start();
        byte_out(8'h89, ack);
        chk("R1 read address ack", 32'(ack), 1);
        for (int i = 0; i < 254; i++) begin
            byte_in(rd, i != 253);
            if (i == 8'h00 || i == 8'h1C)
                chk("R4 read-only byte read back", 32'(rd), 32'(reg_init(i)));
            else
                chk("R4 sequential read", 32'(rd), 32'(reg_pat(i)));
        end
        tick(2*Q);
        chk("R4 sda released after nack", 32'(sda_drive_low), 0);
        bus_stop();

        // R5: cursor port write with wrap
        base = 12;
        bus_start();
        byte_out(8'h88, ack);
        byte_out(8'hFE, ack);
        byte_out(8'(base), ack);
        for (int k = 0; k < 8; k++) begin
            byte_out(8'hA0 + 8'(k), ack);
            chk("R5 cursor byte ack", 32'(ack), 1);
            exp_cur[(base + k) % CUR_N] = 8'hA0 + 8'(k);
        end
        bus_stop();
        chk("R5 cursor strobe count", cur_cnt, 8);
        for (int i = 0; i < CUR_N; i++)
            chk("R5 cursor contents", 32'(cur_mem[i]), 32'(exp_cur[i]));
        chk("R5 no register write from cursor port", reg_cnt, 252);

        // R7: cursor read across the wrap
        bus_start();
        byte_out(8'h88, ack);
        byte_out(8'hFE, ack);
        byte_out(8'd14, ack);
        bus_start();
        byte_out(8'h89, ack);
        for (int k = 0; k < 4; k++) begin
            byte_in(rd, k != 3);
            chk("R7 cursor sequential read", 32'(rd), 32'(exp_cur[(14 + k) % CUR_N]));
        end
        bus_stop();

        // R6: lookup table triplets with wrap, then an incomplete triplet
        base = 6;
        bus_start();
        byte_out(8'h88, ack);
        byte_out(8'hFF, ack);
        byte_out(8'(base), ack);
        for (int k = 0; k < 4; k++) begin
            byte_out(8'h10 + 8'(k), ack);
            byte_out(8'h20 + 8'(k), ack);
            byte_out(8'h30 + 8'(k), ack);
            exp_lut[(base + k) % LUT_N] = {8'h10 + 8'(k), 8'h20 + 8'(k), 8'h30 + 8'(k)};
        end
        byte_out(8'hEE, ack);
        byte_out(8'hDD, ack);
        bus_stop();
        chk("R6 one write per complete triplet", lut_cnt, 4);
        for (int i = 0; i < LUT_N; i++)
            chk("R6 table contents", lut_mem[i], exp_lut[i]);

        // R7: table read returns R, G, B then next entry
        bus_start();
        byte_out(8'h88, ack);
        byte_out(8'hFF, ack);
        byte_out(8'd7, ack);
        bus_start();
        byte_out(8'h89, ack);
        for (int k = 0; k < 6; k++) begin
            logic [23:0] ent;
            ent = exp_lut[(7 + k / 3) % LUT_N];
            byte_in(rd, k != 5);
            chk("R7 table component read", 32'(rd), 32'(ent[23 - 8 * (k % 3) -: 8]));
        end
        bus_stop();

        // R8: STOP mid-byte discards the partial byte
        bus_start();
        byte_out(8'h88, ack);
        byte_out(8'h40, ack);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
        bus_stop();
        chk("R8 no write after stop mid-byte", reg_cnt, 252);
        chk("R8 target unchanged after stop", 32'(reg_mem[8'h40]), 32'(reg_pat(8'h40)));
        bus_start();
        byte_out(8'h88, ack);
        byte_out(8'h41, ack);
        byte_out(8'h5A, ack);
        bus_stop();
        chk("R8 recovery write", 32'(reg_mem[8'h41]), 32'h5A);

        // R8: START mid-byte aborts, new transfer expects a fresh index
        bus_start();
        byte_out(8'h88, ack);
        byte_out(8'h42, ack);
        bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        bus_start();
        byte_out(8'h88, ack);
        chk("R8 address ack after restart", 32'(ack), 1);
        byte_out(8'h43, ack);
        byte_out(8'h66, ack);
        bus_stop();
        chk("R8 index 42h untouched", 32'(reg_mem[8'h42]), 32'(reg_pat(8'h42)));
        chk("R8 fresh index used", 32'(reg_mem[8'h43]), 32'h66);
        chk("R8 strobe count", reg_cnt, 254);
        chk("R9 scl never driven", 32'(scl_drive_low), 0);
        chk("R9 sda released when idle", 32'(sda_drive_low), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule